// File: doc/BRIEF.md
# Microsequenced Accumulator Processor Core

This block is a 16-bit accumulator processor. It carries out every instruction as a chain of single-cycle register transfers among five registers: a program counter, a memory address register, a memory buffer register, an instruction register and the accumulator. Each instruction starts with the same fetch and decode steps. An execute chain chosen by the opcode follows them. Memory sits outside the core behind one synchronous word port. The port uses 12-bit addresses and 16-bit data, and read data comes back one cycle after the address is presented.

An instruction word holds a 4-bit opcode in bits 15:12 and a 12-bit address operand in bits 11:0. The core supports these operations:

- load, store, add and subtract on the accumulator
- an input operation that waits on a strobed input port
- a conditional skip
- a direct jump and an indirect jump
- a call that saves its return address in memory
- a stack-duplicate operation whose stack pointer is kept in a memory word
- a halt that freezes the core until reset

Top module: `acc_core`

## Requirements
- R1: While rst_ni is low, halted_o is 0, mem_we_o is 0 and mem_addr_o is 0. After release, the first instruction is fetched from address 0.
- R2: Opcode 1 (load X) copies M[X] into AC. Opcode 3 (add X) adds M[X] to AC modulo 2^16, so FFFF + FFFF = FFFE.
- R3: Opcode 4 (subtract X) sets AC to AC - M[X] modulo 2^16.
- R4: Opcode 2 (store X) writes AC to M[X]. Every write on the port drives a defined value.
- R5: Opcode 8 (skip) tests operand bits 11:10. 00 skips the next instruction when AC is negative, 01 when AC is zero and 10 when AC is positive. Code 11 never skips.
- R6: Opcode 9 (jump X) continues execution at X.
- R7: Opcode 0 (call X) writes the address of the next instruction to M[X] and continues at X+1. AC is left holding X+1.
- R8: Opcode C (indirect jump X) continues at the address held in M[X], so indirect jump X returns from a call X.
- R9: Opcode D (duplicate X) reads the pointer P from M[X]. It writes M[P] to M[P-1] and writes P-1 back to M[X]. AC keeps its value from before the instruction.
- R10: Opcode 5 (input) waits with no memory write until in_valid_i is high. It then loads in_data_i into AC, with in_ack_o high for exactly that one cycle.
- R11: Opcode 7 (halt) sets halted_o. halted_o stays high until reset, and no write or further fetch happens in the meantime.
- R12: Opcodes 6, A, B, E and F do nothing beyond the fetch and decode steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 12 | Word address; memory samples it every cycle |
| mem_we_o | output | 1 | Write enable for mem_wdata_o at mem_addr_o |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, the word at the address presented on the previous cycle |
| in_data_i | input | 16 | Input port value |
| in_valid_i | input | 1 | Input port strobe |
| in_ack_o | output | 1 | High in the cycle the input value is taken |
| halted_o | output | 1 | Sticky halt flag |

## Verification
The checker assumes that in_valid_i is free of X whenever the core waits for input. It also assumes that memory returns the word for the previous cycle's address, which the bench's memory model provides. The bench drops the strobe one cycle after each observed acknowledge, so no single presented value is taken twice. Every program the bench loads ends in a halt and stays within words that the bench has initialised. Its one stack-duplicate case uses a pointer well away from address 0, so the pointer decrement never wraps.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [3:0] {
    OP_CALL  = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_SUB   = 4'h4,
    OP_IN    = 4'h5,
    OP_HALT  = 4'h7,
    OP_SKIP  = 4'h8,
    OP_JMP   = 4'h9,
    OP_JMPI  = 4'hC,
    OP_DUP   = 4'hD
  } op_e;

  typedef enum logic [4:0] {
    S_F_MAR, S_F_RD, S_F_IR, S_F_PC, S_DEC,
    S_RD, S_OPND, S_EXE,
    S_ST_MBR, S_WR,
    S_IN, S_HALT, S_STOP, S_SKIP, S_JMP,
    S_CL_SAVE, S_CL_ADDR, S_CL_WR, S_CL_X, S_CL_ONE, S_CL_SUM, S_CL_PC,
    S_DP_PTR, S_DP_RD, S_DP_VAL, S_DP_DST, S_DP_WR1, S_DP_SP, S_DP_WR2, S_DP_RST
  } state_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o
);
  always_comb y_o = sub_i ? (a_i - b_i) : (a_i + b_i);
endmodule

// File: rtl/acc_skip.sv
module acc_skip #(
  parameter int W = 16
) (
  input  logic [W-1:0] ac_i,
  input  logic [1:0]   sel_i,
  output logic         take_o
);
  logic neg, zero;
  always_comb begin
    neg  = ac_i[W-1];
    zero = (ac_i == '0);
    unique case (sel_i)
      2'b00:   take_o = neg;
      2'b01:   take_o = zero;
      2'b10:   take_o = !neg && !zero;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic [3:0] op_i,
  input  logic   in_valid_i,
  output state_e state_o
);
  state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_F_MAR:  st_d = S_F_RD;
      S_F_RD:   st_d = S_F_IR;
      S_F_IR:   st_d = S_F_PC;
      S_F_PC:   st_d = S_DEC;
      S_DEC: begin
        unique case (op_i)
          OP_CALL:                                st_d = S_CL_SAVE;
          OP_LOAD, OP_ADD, OP_SUB, OP_JMPI, OP_DUP: st_d = S_RD;
          OP_STORE:                               st_d = S_ST_MBR;
          OP_IN:                                  st_d = S_IN;
          OP_HALT:                                st_d = S_HALT;
          OP_SKIP:                                st_d = S_SKIP;
          OP_JMP:                                 st_d = S_JMP;
          default:                                st_d = S_F_MAR;
        endcase
      end
      S_RD:     st_d = S_OPND;
      S_OPND:   st_d = (op_i == OP_DUP) ? S_DP_PTR : S_EXE;
      S_ST_MBR: st_d = S_WR;
      S_IN:     st_d = in_valid_i ? S_F_MAR : S_IN;
      S_HALT:   st_d = S_STOP;
      S_STOP:   st_d = S_STOP;
      S_CL_SAVE: st_d = S_CL_ADDR;
      S_CL_ADDR: st_d = S_CL_WR;
      S_CL_WR:   st_d = S_CL_X;
      S_CL_X:    st_d = S_CL_ONE;
      S_CL_ONE:  st_d = S_CL_SUM;
      S_CL_SUM:  st_d = S_CL_PC;
      S_DP_PTR:  st_d = S_DP_RD;
      S_DP_RD:   st_d = S_DP_VAL;
      S_DP_VAL:  st_d = S_DP_DST;
      S_DP_DST:  st_d = S_DP_WR1;
      S_DP_WR1:  st_d = S_DP_SP;
      S_DP_SP:   st_d = S_DP_WR2;
      S_DP_WR2:  st_d = S_DP_RST;
      default:   st_d = S_F_MAR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= S_F_MAR;
    else         st_q <= st_d;

  assign state_o = st_q;
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_valid_i,
  output logic          in_ack_o,
  output logic          halted_o
);
  localparam int OPW = DW - AW;

  state_e        st;
  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] ir_q, mbr_q, ac_q, sav_q;
  logic          halt_q;
  logic [OPW-1:0] op;
  logic [AW-1:0] opnd;
  logic [DW-1:0] alu_b, alu_y;
  logic          alu_sub, skip_take;

  assign op   = ir_q[DW-1:AW];
  assign opnd = ir_q[AW-1:0];

  acc_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op[3:0]),
    .in_valid_i (in_valid_i),
    .state_o    (st)
  );

  assign alu_b   = (st == S_DP_RD) ? DW'(1) : mbr_q;
  assign alu_sub = (st == S_DP_RD) || (st == S_EXE && op == OP_SUB);

  acc_alu #(.W(DW)) u_alu (
    .a_i   (ac_q),
    .b_i   (alu_b),
    .sub_i (alu_sub),
    .y_o   (alu_y)
  );

  acc_skip #(.W(DW)) u_skip (
    .ac_i   (ac_q),
    .sel_i  (ir_q[AW-1:AW-2]),
    .take_o (skip_take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      mar_q  <= '0;
      ir_q   <= '0;
      mbr_q  <= '0;
      ac_q   <= '0;
      sav_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      unique case (st)
        S_F_MAR:  mar_q <= pc_q;
        S_F_IR:   ir_q  <= mem_rdata_i;
        S_F_PC:   pc_q  <= pc_q + AW'(1);
        S_DEC:    mar_q <= opnd;
        S_OPND: begin
          mbr_q <= mem_rdata_i;
          sav_q <= ac_q;
        end
        S_EXE: begin
          unique case (op)
            OP_LOAD:       ac_q <= mbr_q;
            OP_ADD, OP_SUB: ac_q <= alu_y;
            OP_JMPI:       pc_q <= mbr_q[AW-1:0];
            default:       ;
          endcase
        end
        S_ST_MBR: mbr_q <= ac_q;
        S_IN:     if (in_valid_i) ac_q <= in_data_i;
        S_HALT:   halt_q <= 1'b1;
        S_SKIP:   if (skip_take) pc_q <= pc_q + AW'(1);
        S_JMP:    pc_q <= mar_q;
        S_CL_SAVE: mbr_q <= {{OPW{1'b0}}, pc_q};
        S_CL_ADDR: mar_q <= opnd;
        S_CL_X:    mbr_q <= {{OPW{1'b0}}, opnd};
        S_CL_ONE:  ac_q  <= DW'(1);
        S_CL_SUM:  ac_q  <= alu_y;
        S_CL_PC:   pc_q  <= ac_q[AW-1:0];
        S_DP_PTR: begin
          mar_q <= mbr_q[AW-1:0];
          ac_q  <= mbr_q;
        end
        S_DP_RD:  ac_q  <= alu_y;
        S_DP_VAL: mbr_q <= mem_rdata_i;
        S_DP_DST: mar_q <= ac_q[AW-1:0];
        S_DP_SP: begin
          mbr_q <= ac_q;
          mar_q <= opnd;
        end
        S_DP_RST: ac_q <= sav_q;
        default:  ;
      endcase
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mbr_q;
  assign mem_we_o    = (st == S_WR) || (st == S_CL_WR) || (st == S_DP_WR1) || (st == S_DP_WR2);
  assign in_ack_o    = (st == S_IN) && in_valid_i;
  assign halted_o    = halt_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          in_valid_i,
  input logic          in_ack_o,
  input logic          halted_o
);
  assert_halt_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  assert_no_write_halted_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o);
  assert_addr_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(mem_addr_o));
  assert_ack_needs_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o |-> in_valid_i);
  assert_ack_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o |=> !in_ack_o);
  assert_ack_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o |-> !mem_we_o);
  assert_wdata_known_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !$isunknown(mem_wdata_o));
endmodule

bind acc_core acc_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .in_valid_i  (in_valid_i),
  .in_ack_o    (in_ack_o),
  .halted_o    (halted_o)
);

// File: tb/tb_acc_core.sv
module tb_acc_core;
  localparam int DW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ack, halted;
  logic [DW-1:0] mem [4096];
  int            n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  acc_core #(.DW(DW), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .in_data_i(in_data),
    .in_valid_i(in_valid), .in_ack_o(in_ack), .halted_o(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    rst_ni = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4096; i++) mem[i] = 16'hDEAD;
  endtask

  task automatic release_and_run(input string req);
    int k;
    @(negedge clk);
    rst_ni = 1'b1;
    k = 0;
    while (!halted && k < 3000) begin
      @(negedge clk);
      k++;
    end
    check({req, " reached halt"}, {15'd0, halted}, 16'd1);
  endtask

  task automatic t_reset();
    clear_mem();
    @(negedge clk);
    check("R1 halted in reset", {15'd0, halted}, 16'd0);
    check("R1 we in reset", {15'd0, mem_we}, 16'd0);
    check("R1 addr in reset", {4'd0, mem_addr}, 16'd0);
    mem[0] = 16'h2021; mem[1] = 16'h7000;
    release_and_run("R1");
    check("R1 start at 0 stores AC=0", mem[12'h021], 16'h0000);
  endtask

  task automatic t_arith();
    clear_mem();
    mem[0] = 16'h1020; mem[1] = 16'h3020; mem[2] = 16'h2021;
    mem[3] = 16'h1022; mem[4] = 16'h4023; mem[5] = 16'h2024;
    mem[6] = 16'h1025; mem[7] = 16'h4026; mem[8] = 16'h2027; mem[9] = 16'h7000;
    mem[12'h020] = 16'hFFFF; mem[12'h022] = 16'h0005; mem[12'h023] = 16'h0007;
    mem[12'h025] = 16'h8000; mem[12'h026] = 16'h0001;
    release_and_run("R2");
    check("R2 FFFF+FFFF", mem[12'h021], 16'hFFFE);
    check("R3 5-7", mem[12'h024], 16'hFFFE);
    check("R3 8000-1", mem[12'h027], 16'h7FFF);
    check("R4 store left source", mem[12'h020], 16'hFFFF);
  endtask

  task automatic t_skip(input logic [DW-1:0] acv, input logic [11:0] sel, input bit skip);
    clear_mem();
    mem[0] = 16'h1020; mem[1] = {4'h8, sel}; mem[2] = 16'h2021; mem[3] = 16'h7000;
    mem[12'h020] = acv;
    release_and_run("R5");
    check($sformatf("R5 skip ac=%h sel=%h", acv, sel), mem[12'h021], skip ? 16'hDEAD : acv);
  endtask

  task automatic t_jump();
    clear_mem();
    mem[0] = 16'h9005; mem[1] = 16'h2022; mem[2] = 16'h7000;
    mem[5] = 16'h1020; mem[6] = 16'h2021; mem[7] = 16'h7000;
    mem[12'h020] = 16'h4242;
    release_and_run("R6");
    check("R6 target ran", mem[12'h021], 16'h4242);
    check("R6 skipped words untouched", mem[12'h022], 16'hDEAD);
  endtask

  task automatic t_call();
    clear_mem();
    mem[0] = 16'h1020; mem[1] = 16'h0030; mem[2] = 16'h2022; mem[3] = 16'h7000;
    mem[12'h031] = 16'h2021; mem[12'h032] = 16'hC030;
    mem[12'h020] = 16'h7777;
    release_and_run("R7");
    check("R7 return addr saved", mem[12'h030], 16'h0002);
    check("R7 AC=X+1 in body", mem[12'h021], 16'h0031);
    check("R8 returned after call", mem[12'h022], 16'h0031);
  endtask

  task automatic t_dup();
    clear_mem();
    mem[0] = 16'h1020; mem[1] = 16'hDFFF; mem[2] = 16'h2021; mem[3] = 16'h7000;
    mem[12'h020] = 16'h5A5A; mem[12'hFFF] = 16'h0F01; mem[12'hF01] = 16'h1234;
    release_and_run("R9");
    check("R9 copy below top", mem[12'hF00], 16'h1234);
    check("R9 pointer decremented", mem[12'hFFF], 16'h0F00);
    check("R9 old top kept", mem[12'hF01], 16'h1234);
    check("R9 AC preserved", mem[12'h021], 16'h5A5A);
  endtask

  task automatic t_input();
    logic [DW-1:0] v [2];
    v[0] = 16'hBEEF; v[1] = 16'h0123;
    clear_mem();
    mem[0] = 16'h5000; mem[1] = 16'h2032; mem[2] = 16'h5000; mem[3] = 16'h2033; mem[4] = 16'h7000;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int s = 0; s < 2; s++) begin
      repeat (12) @(negedge clk);
      check("R10 waits no ack", {15'd0, in_ack}, 16'd0);
      check("R10 waits no halt", {15'd0, halted}, 16'd0);
      if (s == 0) check("R10 no store while waiting", mem[12'h032], 16'hDEAD);
      in_data = v[s];
      in_valid = 1'b1;
      #1;
      check("R10 ack with valid", {15'd0, in_ack}, 16'd1);
      @(posedge clk);
      @(negedge clk);
      check("R10 ack one cycle", {15'd0, in_ack}, 16'd0);
      in_valid = 1'b0;
      in_data = 16'h0000;
    end
    for (int k = 0; k < 200 && !halted; k++) @(negedge clk);
    check("R10 first value", mem[12'h032], 16'hBEEF);
    check("R10 second value", mem[12'h033], 16'h0123);
  endtask

  task automatic t_halt();
    logic [AW-1:0] a;
    clear_mem();
    mem[0] = 16'h1020; mem[1] = 16'h7000; mem[2] = 16'h2021; mem[3] = 16'h2022;
    mem[12'h020] = 16'h1111;
    release_and_run("R11");
    a = mem_addr;
    repeat (60) @(negedge clk);
    check("R11 halt sticky", {15'd0, halted}, 16'd1);
    check("R11 no store after halt", mem[12'h021], 16'hDEAD);
    check("R11 no fetch after halt", {4'd0, mem_addr}, {4'd0, a});
  endtask

  task automatic t_undef();
    clear_mem();
    mem[0] = 16'h1020; mem[1] = 16'h6021; mem[2] = 16'hA021; mem[3] = 16'hB021;
    mem[4] = 16'hE021; mem[5] = 16'hF021; mem[6] = 16'h2022; mem[7] = 16'h7000;
    mem[12'h020] = 16'h0C0C;
    release_and_run("R12");
    check("R12 AC unchanged", mem[12'h022], 16'h0C0C);
    check("R12 no write at operand", mem[12'h021], 16'hDEAD);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_skip(16'h8001, 12'h000, 1'b1);
    t_skip(16'h0003, 12'h000, 1'b0);
    t_skip(16'h0000, 12'h400, 1'b1);
    t_skip(16'hFFFF, 12'h400, 1'b0);
    t_skip(16'h0005, 12'h800, 1'b1);
    t_skip(16'h0000, 12'h800, 1'b0);
    t_skip(16'h8000, 12'hC00, 1'b0);
    t_jump();
    t_call();
    t_dup();
    t_input();
    t_halt();
    t_undef();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule